// File: doc/BRIEF.md
# Pipeline Hazard and Redirect Controller

This block is the control logic for a six-stage, in-order scalar pipeline. The stages, in order, are two fetch stages (front and back), decode, execute, memory-align and writeback. The two-stage fetch suits an instruction memory with a fixed one-cycle read latency. Branch and jump outcomes are resolved only in execute. From the per-stage valid bits, the register numbers of the execute and decode instructions, a redirect request from execute and a memory wait input, the block produces three things: a hold and a bubble control for each stage, a next-PC select, and the redirect address.

A taken branch or jump discards the three younger instructions in fetch and decode, so it costs four cycles in total. A load followed at once by a consumer of its result costs one stall cycle. Every other sequence runs at one instruction per cycle.

The memory wait input behaves like a wait-request and freezes every stage. A redirect that arrives during a wait is held back and applied in the first cycle after the wait ends. A target that is misaligned or beyond the attached memory does not fault at the branch: the branch still retires with its side effects. A fetch fault is raised in the cycle after the redirect is taken.

Top module: `hz_ctrl`

## Requirements
- R1: After reset `fetch_fault` is 0, and with idle inputs `stall` and `flush` are 0 and `pc_sel` is 0 (sequential).
- R2: While `mem_wait` is 1, all six `stall` bits are 1, all `flush` bits are 0 and `pc_sel` is 1 (hold).
- R3: A redirect (`ex_redirect` with `stage_valid[3]`, no wait) sets `flush` bits 0, 1 and 2 (both fetch stages and decode), sets no `stall` bit, sets `pc_sel` to 2 (redirect) and drives `redirect_pc` to `ex_target`.
- R4: A redirect never flushes bits 3 to 5 (execute, memory-align, writeback), so the branch itself retires with its side effects.
- R5: A load-use hazard stalls bits 0 to 2, flushes bit 3 (one bubble into execute) and sets `pc_sel` to 1. The hazard exists when stage_valid[3] and stage_valid[2] are set, `ex_is_load` is 1, `ex_rd` is nonzero, and `dec_rs1` or `dec_rs2` equals `ex_rd`.
- R6: No load-use hazard is raised when `ex_rd` is 0, when the execute instruction is not a load, or when either of those two stages is invalid.
- R7: With no wait, no redirect and no hazard, `stall` and `flush` are 0 and `pc_sel` is 0.
- R8: A redirect seen while `mem_wait` is 1 is captured with its target. In the first cycle with `mem_wait` at 0, it is applied as in R3 using the captured target.
- R9: A target whose bits [1:0] are nonzero, or that has a nonzero bit at or above position WORD_AW+2, raises `fetch_fault` in the cycle after the redirect is applied. The fault stays high through any following wait cycles and drops in the first cycle without a wait.
- R10: A redirect takes priority over a load-use hazard in the same cycle.
- R11: No stage ever has its `stall` and `flush` bits set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_valid | input | 6 | Valid bit per stage, bit 0 = fetch front through bit 5 = writeback |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| dec_rs1 | input | REG_AW | First source register of the decode instruction |
| dec_rs2 | input | REG_AW | Second source register of the decode instruction |
| ex_redirect | input | 1 | Execute has a taken branch or jump |
| ex_target | input | XLEN | Byte address of the branch or jump target |
| mem_wait | input | 1 | Memory wait-request, freezes the pipeline |
| stall | output | 6 | Per-stage hold |
| flush | output | 6 | Per-stage bubble |
| pc_sel | output | 2 | Next PC: 0 sequential, 1 hold, 2 redirect |
| redirect_pc | output | XLEN | Redirect address, valid when pc_sel is 2 |
| fetch_fault | output | 1 | Fetch fault for a bad redirect target |

## Verification
`stall`, `flush`, `pc_sel` and `redirect_pc` are combinational from the present inputs and the pending-redirect register, so they are due in the same cycle as the stimulus. `fetch_fault` passes through one register and is due one edge after the redirect is applied. The bench drives inputs on the falling edge, compares all outputs a nanosecond later, and only then advances its model of the pending redirect and the fault at the rising edge. Each comparison therefore sees the state that the previous edge left behind.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NSTAGE = 6;
  localparam int ST_F1  = 0;
  localparam int ST_F2  = 1;
  localparam int ST_DEC = 2;
  localparam int ST_EX  = 3;
  localparam int ST_MA  = 4;
  localparam int ST_WB  = 5;

  typedef enum logic [1:0] {
    PC_SEQ   = 2'd0,
    PC_HOLD  = 2'd1,
    PC_REDIR = 2'd2
  } pc_sel_e;
endpackage

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
  parameter int REG_AW = 5,
  parameter int NSRC   = 2
) (
  input  logic              ex_valid,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              dec_valid,
  input  logic [REG_AW-1:0] dec_rs [NSRC],
  output logic              hazard
);
  logic [NSRC-1:0] match;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign match[s] = (dec_rs[s] == ex_rd);
  end

  assign hazard = ex_valid && ex_is_load && (ex_rd != '0) && dec_valid && (|match);
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect #(
  parameter int XLEN    = 32,
  parameter int WORD_AW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mem_wait,
  input  logic            ex_valid,
  input  logic            ex_redirect,
  input  logic [XLEN-1:0] ex_target,
  output logic            apply,
  output logic [XLEN-1:0] target,
  output logic            fetch_fault
);
  localparam int LIM_BIT = WORD_AW + 2;

  logic            pend_q;
  logic [XLEN-1:0] pend_tgt_q;
  logic            fault_q;
  logic            req_now;
  logic            bad_tgt;

  assign req_now = ex_valid && ex_redirect;
  assign apply   = !mem_wait && (pend_q || req_now);
  assign target  = pend_q ? pend_tgt_q : ex_target;

  generate
    if (LIM_BIT < XLEN) begin : g_lim
      assign bad_tgt = (target[1:0] != 2'b00) || (target[XLEN-1:LIM_BIT] != '0);
    end else begin : g_nolim
      assign bad_tgt = (target[1:0] != 2'b00);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_tgt_q <= '0;
      fault_q    <= 1'b0;
    end else begin
      if (mem_wait && req_now) begin
        pend_q     <= 1'b1;
        pend_tgt_q <= ex_target;
      end else if (!mem_wait) begin
        pend_q <= 1'b0;
      end
      if (apply && bad_tgt) fault_q <= 1'b1;
      else if (!mem_wait)   fault_q <= 1'b0;
    end
  end

  assign fetch_fault = fault_q;
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int WORD_AW = 12,
  parameter int REG_AW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        stage_valid,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic [REG_AW-1:0] dec_rs1,
  input  logic [REG_AW-1:0] dec_rs2,
  input  logic              ex_redirect,
  input  logic [XLEN-1:0]   ex_target,
  input  logic              mem_wait,
  output logic [5:0]        stall,
  output logic [5:0]        flush,
  output logic [1:0]        pc_sel,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              fetch_fault
);
  logic              lu_hit;
  logic              lu_eff;
  logic              redir_apply;
  logic [REG_AW-1:0] rs_vec [2];

  assign rs_vec[0] = dec_rs1;
  assign rs_vec[1] = dec_rs2;

  hz_loaduse #(.REG_AW(REG_AW), .NSRC(2)) u_lu (
    .ex_valid   (stage_valid[ST_EX]),
    .ex_is_load (ex_is_load),
    .ex_rd      (ex_rd),
    .dec_valid  (stage_valid[ST_DEC]),
    .dec_rs     (rs_vec),
    .hazard     (lu_hit)
  );

  hz_redirect #(.XLEN(XLEN), .WORD_AW(WORD_AW)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .mem_wait    (mem_wait),
    .ex_valid    (stage_valid[ST_EX]),
    .ex_redirect (ex_redirect),
    .ex_target   (ex_target),
    .apply       (redir_apply),
    .target      (redirect_pc),
    .fetch_fault (fetch_fault)
  );

  assign lu_eff = lu_hit && !redir_apply && !mem_wait;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i <= ST_DEC) begin : g_front
      assign stall[i] = mem_wait || lu_eff;
      assign flush[i] = redir_apply;
    end else if (i == ST_EX) begin : g_ex
      assign stall[i] = mem_wait;
      assign flush[i] = lu_eff;
    end else begin : g_back
      assign stall[i] = mem_wait;
      assign flush[i] = 1'b0;
    end
  end

  always_comb begin
    if (redir_apply)             pc_sel = PC_REDIR;
    else if (mem_wait || lu_eff) pc_sel = PC_HOLD;
    else                         pc_sel = PC_SEQ;
  end
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int XLEN    = 32,
  parameter int WORD_AW = 12,
  parameter int REG_AW  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [5:0]        stage_valid,
  input logic              ex_is_load,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_redirect,
  input logic              mem_wait,
  input logic [5:0]        stall,
  input logic [5:0]        flush,
  input logic [1:0]        pc_sel,
  input logic [XLEN-1:0]   redirect_pc,
  input logic              fetch_fault
);
  logic bad_pc;
  assign bad_pc = (redirect_pc[1:0] != 2'b00) || ((redirect_pc >> (WORD_AW + 2)) != '0);

  // R2
  wait_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wait |-> (stall == 6'h3f && flush == 6'h00 && pc_sel == 2'd1));

  // R4
  branch_survives_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'd2) |-> (flush[5:3] == 3'b000 && flush[2:0] == 3'b111));

  // R6
  no_x0_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_rd == '0 && !(stage_valid[3] && ex_redirect)) |-> !flush[3]);

  // R8
  deferred_redir_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_wait && stage_valid[3] && ex_redirect) && !mem_wait) |-> (pc_sel == 2'd2));

  // R9
  late_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'd2 && bad_pc) |=> fetch_fault);

  // R11
  excl_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(stall & flush) == 0);

  // R5
  loaduse_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (flush[3] && !mem_wait) |-> (stall == 6'b000111 && ex_is_load && pc_sel == 2'd1));
endmodule

bind hz_ctrl hz_ctrl_chk #(.XLEN(XLEN), .WORD_AW(WORD_AW), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .stage_valid(stage_valid), .ex_is_load(ex_is_load), .ex_rd(ex_rd),
  .ex_redirect(ex_redirect), .mem_wait(mem_wait), .stall(stall), .flush(flush),
  .pc_sel(pc_sel), .redirect_pc(redirect_pc), .fetch_fault(fetch_fault)
);

// File: tb/tb_hz_ctrl.sv
module tb_hz_ctrl;
  localparam int XLEN = 32, WORD_AW = 12, REG_AW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] stage_valid = '0;
  logic ex_is_load = 0, ex_redirect = 0, mem_wait = 0;
  logic [REG_AW-1:0] ex_rd = '0, dec_rs1 = '0, dec_rs2 = '0;
  logic [XLEN-1:0] ex_target = '0;
  logic [5:0] stall, flush;
  logic [1:0] pc_sel;
  logic [XLEN-1:0] redirect_pc;
  logic fetch_fault;

  int n_chk = 0, n_bad = 0;
  logic pend_m = 0, fault_m = 0;
  logic [XLEN-1:0] ptgt_m = '0;

  always #4 clk = ~clk;

  hz_ctrl #(.XLEN(XLEN), .WORD_AW(WORD_AW), .REG_AW(REG_AW)) dut (.*);

  function automatic logic bad_target(logic [XLEN-1:0] t);
    return (t[1:0] != 2'b00) || ((t >> (WORD_AW + 2)) != 0);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare at the current inputs, then advance the model over one edge.
  task automatic step();
    logic apply, lu, lu_eff, req;
    logic [XLEN-1:0] tgt;
    logic [5:0] es, ef;
    logic [1:0] ep;
    string tag;
    #1;
    req    = stage_valid[3] && ex_redirect;
    apply  = !mem_wait && (pend_m || req);
    tgt    = pend_m ? ptgt_m : ex_target;
    lu     = stage_valid[3] && stage_valid[2] && ex_is_load && ex_rd != 0 &&
             (dec_rs1 == ex_rd || dec_rs2 == ex_rd);
    lu_eff = lu && !apply && !mem_wait;
    if (mem_wait)    begin es = 6'h3f;     ef = 6'h00;     ep = 2'd1; tag = "R2"; end
    else if (apply)  begin es = 6'h00;     ef = 6'b000111; ep = 2'd2;
                           tag = pend_m ? "R8" : (lu ? "R10" : "R3"); end
    else if (lu_eff) begin es = 6'b000111; ef = 6'b001000; ep = 2'd1; tag = "R5"; end
    else             begin es = 6'h00;     ef = 6'h00;     ep = 2'd0;
                           tag = (stage_valid[3] && ex_is_load) ? "R6" : "R7"; end
    chk({tag, " stall"}, 64'(stall), 64'(es));
    chk({tag, " flush"}, 64'(flush), 64'(ef));
    chk({tag, " pc_sel"}, 64'(pc_sel), 64'(ep));
    if (apply) begin
      chk({tag, " redirect_pc"}, 64'(redirect_pc), 64'(tgt));
      chk("R4 older stages kept", 64'(flush[5:3]), 64'd0);
    end
    chk("R9 fetch_fault", 64'(fetch_fault), 64'(fault_m));
    @(posedge clk);
    if (apply && bad_target(tgt)) fault_m = 1;
    else if (!mem_wait)           fault_m = 0;
    if (mem_wait && req) begin pend_m = 1; ptgt_m = ex_target; end
    else if (!mem_wait) pend_m = 0;
    @(negedge clk);
  endtask

  task automatic drive(logic [5:0] v, logic ld, logic [4:0] rd, logic [4:0] r1, logic [4:0] r2,
                       logic br, logic [31:0] t, logic w);
    stage_valid = v; ex_is_load = ld; ex_rd = rd; dec_rs1 = r1; dec_rs2 = r2;
    ex_redirect = br; ex_target = t; mem_wait = w;
  endtask

  initial begin : watchdog
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state with idle inputs
    chk("R1 fetch_fault", 64'(fetch_fault), 64'd0);
    step();
    // R7 plain flow
    drive(6'h3f, 0, 5, 5, 5, 0, 0, 0); step();
    // R5 load-use on rs1 and rs2
    drive(6'h3f, 1, 7, 7, 3, 0, 0, 0); step();
    drive(6'h3f, 1, 7, 2, 7, 0, 0, 0); step();
    // R6 x0 destination, invalid decode, non-load
    drive(6'h3f, 1, 0, 0, 0, 0, 0, 0); step();
    drive(6'h3b, 1, 7, 7, 7, 0, 0, 0); step();
    drive(6'h3f, 0, 7, 7, 7, 0, 0, 0); step();
    // R3 aligned redirect, no fault
    drive(6'h3f, 0, 1, 1, 1, 1, 32'h100, 0); step();
    drive(6'h3f, 0, 0, 0, 0, 0, 0, 0); step();
    // R9 misaligned target, fault held through a wait
    drive(6'h3f, 0, 0, 0, 0, 1, 32'h102, 0); step();
    drive(6'h3f, 0, 0, 0, 0, 0, 0, 1); step();
    drive(6'h3f, 0, 0, 0, 0, 0, 0, 0); step();
    // R9 out-of-range target
    drive(6'h3f, 0, 0, 0, 0, 1, 32'h0001_0000, 0); step();
    drive(6'h3f, 0, 0, 0, 0, 0, 0, 0); step();
    // R8 redirect during a two-cycle wait, target changes afterwards
    drive(6'h3f, 0, 0, 0, 0, 1, 32'h204, 1); step();
    drive(6'h3f, 0, 0, 0, 0, 1, 32'h204, 1); step();
    drive(6'h3f, 0, 0, 0, 0, 0, 32'h999, 0); step();
    // R10 redirect outranks a load-use match
    drive(6'h3f, 1, 4, 4, 4, 1, 32'h40, 0); step();
    // R2 wait freezes with a load-use pattern present
    drive(6'h3f, 1, 4, 4, 4, 0, 0, 1); step();
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] t;
      t = ($urandom % 4 == 0) ? $urandom : (($urandom % 1024) << 2);
      drive(6'($urandom), 1'($urandom), 5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4),
            ($urandom % 5 == 0), t, ($urandom % 4 == 0));
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule